// File: doc/BRIEF.md
# Address Table Indirect Access Port

This block holds a table of address-lookup entries. Each entry is 68 bits wide. Software never addresses the table storage directly. It reaches the table through a small register window on a simple synchronous read/write bus. The window has three data-word registers and one index register.

To store an entry, software first writes the three data words. It then writes the target index with the commit flag set. To read an entry, software writes the index with the commit flag clear. The block copies the addressed entry into the data words, and software reads them back.

Two further registers complete the window. An identification register reports the revision. A control register holds a global enable and a clear command. The clear command sweeps the table one entry per cycle and marks every entry free. The same sweep runs after every reset, because the table storage itself has no reset.

Top module: `lut_access_port`

## Requirements
- R1: A read of offset 0x00 returns the minor revision in bits 7:0 and the major revision in bits 15:8, with zero above; the default value is 0x00000104.
- R2: After reset the block sweeps the whole table. Control bit 30 reads 1 during the sweep and 0 once it is done. Every entry then loads as all zeros, which is entry type 0 (free).
- R3: Control bit 31 at offset 0x08 is an enable flag. It reads back the last value written to it and is 0 after reset.
- R4: An index write (offset 0x20) with bit 31 set stores the three staged data words into the entry selected by bits 15:0. The index register reads back those 16 bits, with bit 31 reading 0.
- R5: An index write with bit 31 clear loads the selected entry into the data words, readable from the second cycle after the write. Offset 0x34 bits 3:0 hold entry bits 67:64 and its upper 28 bits read 0. Offset 0x38 holds entry bits 63:32, and offset 0x3C holds entry bits 31:0.
- R6: The entry type field is entry bits 61:60, which is bits 29:28 of offset 0x38 (0 free, 1 address, 2 VLAN, 3 VLAN plus address). All four codes survive a store and a load unchanged.
- R7: An index of DEPTH or more is ignored on store, so no entry changes. The same index loads all-zero data words.
- R8: Writing control bit 30 while no sweep runs starts a sweep that frees every entry. The sweep takes DEPTH cycles, and the bit then reads 0 again without any further write.
- R9: While a sweep runs, writes to the index register are ignored. They store nothing, load nothing and leave the index register unchanged.
- R10: If the bus writes a data word in the same cycle a load lands, that word keeps the bus value. The other words take the loaded entry.
- R11: Read data appears on the cycle after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A load lands in the data words one cycle after its index write. The bench provokes a collision by holding the write strobe across two cycles: the first cycle writes the index and the second writes the middle data word. It then judges the result by reading all three words, expecting the bus value in the middle word and the stored entry in the other two.

A second collision pairs a running sweep with index writes. A store aimed at an entry the sweep has already passed, together with a load that would move the index, must leave both that entry and the index register untouched.

// File: rtl/lut_access_pkg.sv
package lut_access_pkg;

  localparam int WORD_W = 32;
  localparam int HI_W   = 4;
  localparam int ENTRY_W = HI_W + 2 * WORD_W;

  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_IDX  = 8'h20;
  localparam logic [7:0] OFS_WHI  = 8'h34;
  localparam logic [7:0] OFS_WMID = 8'h38;
  localparam logic [7:0] OFS_WLO  = 8'h3C;

  localparam int CTRL_EN_BIT    = 31;
  localparam int CTRL_SWEEP_BIT = 30;
  localparam int IDX_COMMIT_BIT = 31;

  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } entry_kind_e;

  typedef struct packed {
    logic [HI_W-1:0]   hi;
    logic [WORD_W-1:0] mid;
    logic [WORD_W-1:0] lo;
  } lut_entry_t;

endpackage

// File: rtl/lut_store.sv
module lut_store
  import lut_access_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  lut_entry_t      wd,
  input  logic [AW-1:0]   ra,
  output lut_entry_t      rd
);

  lut_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd <= mem[ra];
  end

endmodule

// File: rtl/lut_sweep.sv
module lut_sweep #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
        addr <= '0;
      end else begin
        addr <= addr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end

endmodule

// File: rtl/lut_stage.sv
module lut_stage
  import lut_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        word_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              land,
  input  logic              land_zero,
  input  lut_entry_t        land_entry,
  output lut_entry_t        staged
);

  lut_entry_t src;

  always_comb begin
    src = land_zero ? '0 : land_entry;
  end

  // Bus writes are placed after the load so they win in a shared cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
    end else begin
      if (land) staged <= src;
      if (word_wr[0]) staged.hi  <= wdata[HI_W-1:0];
      if (word_wr[1]) staged.mid <= wdata;
      if (word_wr[2]) staged.lo  <= wdata;
    end
  end

endmodule

// File: rtl/lut_access_port.sv
module lut_access_port
  import lut_access_pkg::*;
#(
  parameter int         DEPTH     = 64,
  parameter int         IDXF_W    = 16,
  parameter logic [7:0] REV_MAJOR = 8'h01,
  parameter logic [7:0] REV_MINOR = 8'h04
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDXF_W:0] DEPTH_X = (IDXF_W + 1)'(DEPTH);

  logic              en_q;
  logic [IDXF_W-1:0] idx_q;
  logic              clr_busy;
  logic [AW-1:0]     clr_addr;
  logic              clr_req;
  logic              idx_acc;
  logic [IDXF_W-1:0] idx_field;
  logic              in_rng;
  logic              commit;
  logic              load;
  logic              land_q;
  logic              land_zero_q;
  logic [2:0]        word_wr;
  logic              ram_we;
  logic [AW-1:0]     ram_wa;
  logic [AW-1:0]     ram_ra;
  lut_entry_t        ram_wd;
  lut_entry_t        ram_rd;
  lut_entry_t        staged;

  // Decode
  always_comb begin
    idx_field = bus_wdata[IDXF_W-1:0];
    in_rng    = {1'b0, idx_field} < DEPTH_X;
    idx_acc   = bus_wr && (bus_addr == OFS_IDX) && !clr_busy;
    commit    = idx_acc && bus_wdata[IDX_COMMIT_BIT] && in_rng;
    load      = idx_acc && !bus_wdata[IDX_COMMIT_BIT];
    clr_req   = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_SWEEP_BIT];
    word_wr[0] = bus_wr && (bus_addr == OFS_WHI);
    word_wr[1] = bus_wr && (bus_addr == OFS_WMID);
    word_wr[2] = bus_wr && (bus_addr == OFS_WLO);
  end

  // Storage port mux: the sweep owns the write port while it runs
  always_comb begin
    ram_we = clr_busy || commit;
    ram_wa = clr_busy ? clr_addr : idx_field[AW-1:0];
    ram_wd = clr_busy ? '0 : staged;
    ram_ra = idx_field[AW-1:0];
  end

  lut_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk (clk),
    .we  (ram_we),
    .wa  (ram_wa),
    .wd  (ram_wd),
    .ra  (ram_ra),
    .rd  (ram_rd)
  );

  lut_sweep #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .start (clr_req),
    .busy  (clr_busy),
    .addr  (clr_addr)
  );

  lut_stage u_stage (
    .clk        (clk),
    .rst        (rst),
    .word_wr    (word_wr),
    .wdata      (bus_wdata),
    .land       (land_q),
    .land_zero  (land_zero_q),
    .land_entry (ram_rd),
    .staged     (staged)
  );

  // Control state
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      idx_q       <= '0;
      land_q      <= 1'b0;
      land_zero_q <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == OFS_CTRL)) en_q <= bus_wdata[CTRL_EN_BIT];
      if (idx_acc) idx_q <= idx_field;
      land_q      <= load;
      land_zero_q <= !in_rng;
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_ID:   bus_rdata <= {16'h0000, REV_MAJOR, REV_MINOR};
        OFS_CTRL: bus_rdata <= {en_q, clr_busy, 30'h0};
        OFS_IDX:  bus_rdata <= 32'(idx_q);
        OFS_WHI:  bus_rdata <= 32'(staged.hi);
        OFS_WMID: bus_rdata <= staged.mid;
        OFS_WLO:  bus_rdata <= staged.lo;
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/lut_access_port_chk.sv
module lut_access_port_chk #(
  parameter int DEPTH  = 64,
  parameter int IDXF_W = 16,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              clr_busy,
  input logic [IDXF_W-1:0] idx_q,
  input logic              ram_we,
  input logic [AW-1:0]     ram_wa,
  input logic [67:0]       ram_wd,
  input logic [67:0]       staged
);

  localparam logic [IDXF_W:0] DEPTH_X = (IDXF_W + 1)'(DEPTH);

  int busy_run;
  logic idx_wr;
  logic idx_ok;

  always_ff @(posedge clk) begin
    if (rst || !clr_busy) busy_run <= 0;
    else                  busy_run <= busy_run + 1;
  end

  always_comb begin
    idx_wr = bus_wr && (bus_addr == 8'h20);
    idx_ok = {1'b0, bus_wdata[IDXF_W-1:0]} < DEPTH_X;
  end

  a_r2_sweep_after_reset: assert property (@(posedge clk)
    rst |=> clr_busy);

  a_r8_sweep_bounded: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> busy_run < DEPTH);

  a_r8_sweep_writes_free: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> (ram_we && ram_wd == '0));

  a_r9_index_frozen: assert property (@(posedge clk) disable iff (rst)
    (clr_busy && idx_wr) |=> $stable(idx_q));

  a_r7_far_index_no_store: assert property (@(posedge clk) disable iff (rst)
    (!clr_busy && idx_wr && bus_wdata[31] && !idx_ok) |-> !ram_we);

  a_r4_store_staged: assert property (@(posedge clk) disable iff (rst)
    (!clr_busy && idx_wr && bus_wdata[31] && idx_ok) |->
      (ram_we && ram_wa == bus_wdata[AW-1:0] && ram_wd == staged));

endmodule

bind lut_access_port lut_access_port_chk #(
  .DEPTH(DEPTH), .IDXF_W(IDXF_W), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .clr_busy  (clr_busy),
  .idx_q     (idx_q),
  .ram_we    (ram_we),
  .ram_wa    (ram_wa),
  .ram_wd    (ram_wd),
  .staged    (staged)
);

// File: tb/lut_access_port_test.sv
module lut_access_port_test;

  localparam int DEPTH = 64;
  localparam int NV = 6;
  // {index, hi nibble, mid word, lo word}
  localparam logic [83:0] VEC [NV] = '{
    {16'd1,  4'hF, 32'h1000_ABCD, 32'h1234_5678},
    {16'd2,  4'h3, 32'h2123_0010, 32'hDEAD_BEEF},
    {16'd62, 4'h0, 32'h3FFF_FFFF, 32'hFFFF_FFFF},
    {16'd63, 4'hC, 32'h0555_0000, 32'h0000_0001},
    {16'd10, 4'h5, 32'hF0F0_F0F0, 32'hA5A5_A5A5},
    {16'd0,  4'h1, 32'h1AAA_AAAA, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lut_access_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    br(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    runs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R3: sweep after reset, enable cleared
    read_check("R2 sweep busy after reset", 8'h08, 32'h4000_0000);
    repeat (DEPTH + 4) @(negedge clk);
    read_check("R2 R3 control idle after reset", 8'h08, 32'h0000_0000);
    bw(8'h20, 32'h0000_0003);
    read_check("R2 entry free after reset (hi)", 8'h34, 32'h0);
    read_check("R2 entry free after reset (mid)", 8'h38, 32'h0);
    read_check("R2 entry free after reset (lo)", 8'h3C, 32'h0);

    // R1 / R11
    read_check("R1 revision", 8'h00, 32'h0000_0104);
    read_check("R11 unmapped 0x04", 8'h04, 32'h0);
    read_check("R11 unmapped 0x30", 8'h30, 32'h0);

    // R3 enable
    bw(8'h08, 32'h8000_0000);
    read_check("R3 enable set", 8'h08, 32'h8000_0000);

    // R4 / R6: store the vector table
    for (int i = 0; i < NV; i++) begin
      bw(8'h34, 32'(VEC[i][67:64]));
      bw(8'h38, VEC[i][63:32]);
      bw(8'h3C, VEC[i][31:0]);
      bw(8'h20, 32'h8000_0000 | 32'(VEC[i][83:68]));
    end
    read_check("R4 index readback", 8'h20, 32'h0000_0000);

    // R5 / R6: load and compare
    for (int i = 0; i < NV; i++) begin
      bw(8'h20, 32'(VEC[i][83:68]));
      read_check("R5 load hi word", 8'h34, 32'(VEC[i][67:64]));
      br(8'h38, v);
      chk("R5 load mid word", v, VEC[i][63:32]);
      chk("R6 entry type field", 32'(v[29:28]), 32'(VEC[i][61:60]));
      read_check("R5 load lo word", 8'h3C, VEC[i][31:0]);
      read_check("R4 index readback", 8'h20, 32'(VEC[i][83:68]));
    end

    // R7: far index ignored on store, zero on load
    bw(8'h34, 32'h0000_0007);
    bw(8'h38, 32'h1111_1111);
    bw(8'h3C, 32'h2222_2222);
    bw(8'h20, 32'h8000_0040);
    bw(8'h20, 32'h0000_0040);
    read_check("R7 far load hi zero", 8'h34, 32'h0);
    read_check("R7 far load mid zero", 8'h38, 32'h0);
    read_check("R7 far load lo zero", 8'h3C, 32'h0);
    bw(8'h20, 32'h0000_0000);
    read_check("R7 entry 0 untouched", 8'h38, 32'h1AAA_AAAA);
    bw(8'h20, 32'h0000_003F);
    read_check("R7 entry 63 untouched", 8'h3C, 32'h0000_0001);

    // R10: data word write in the cycle the load lands
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    bus_addr = 8'h38; bus_wdata = 32'h7777_7777;
    @(negedge clk);
    bus_wr = 1'b0;
    read_check("R10 bus word wins", 8'h38, 32'h7777_7777);
    read_check("R10 other word loaded (hi)", 8'h34, 32'h0000_0003);
    read_check("R10 other word loaded (lo)", 8'h3C, 32'hDEAD_BEEF);

    // R8: commanded sweep, self-clearing after DEPTH cycles
    bw(8'h08, 32'hC000_0000);
    read_check("R8 sweep running", 8'h08, 32'hC000_0000);
    repeat (DEPTH - 12) @(negedge clk);
    read_check("R8 sweep still running", 8'h08, 32'hC000_0000);
    repeat (14) @(negedge clk);
    read_check("R8 sweep self-cleared", 8'h08, 32'h8000_0000);
    bw(8'h20, 32'h0000_000A);
    read_check("R8 entry freed", 8'h38, 32'h0);

    // R9: index writes during a sweep are ignored
    bw(8'h20, 32'h0000_0005);
    bw(8'h34, 32'h0000_0009);
    bw(8'h38, 32'h3333_3333);
    bw(8'h3C, 32'h4444_4444);
    bw(8'h08, 32'hC000_0000);
    bw(8'h20, 32'h8000_0000);
    bw(8'h20, 32'h0000_0007);
    read_check("R9 index unchanged", 8'h20, 32'h0000_0005);
    read_check("R9 stage not reloaded", 8'h38, 32'h3333_3333);
    repeat (DEPTH + 4) @(negedge clk);
    read_check("R9 sweep done", 8'h08, 32'h8000_0000);
    bw(8'h20, 32'h0000_0000);
    read_check("R9 no store during sweep (hi)", 8'h34, 32'h0);
    read_check("R9 no store during sweep (mid)", 8'h38, 32'h0);

    finish_run();
  end

endmodule